// File: doc/BRIEF.md
# Microcoded DMA Channel Sequencer

This block is one DMA channel thread driven by a short byte-coded program. The program sits in a small local program memory that is written through a byte-wide port. A `start` pulse makes the sequencer fetch and run it from byte 0. The program sets a channel control word and the source and destination address registers with immediate values. It then issues read bursts and write bursts shaped by those registers. A single non-nesting counted loop repeats a stretch of instructions.

Each burst leaves the block as a descriptor on a valid/ready port. The descriptor gives the direction, start address, beat count, beat width and whether the address stays fixed. The sequencer then waits for a completion pulse on `cmp_ack` before it fetches the next instruction. Once the burst completes, the address register advances past the bytes moved unless the fixed flag is set. The next burst on the same side therefore continues where the last one stopped, with no alignment to the burst size.

An end instruction raises `done` for one cycle and returns the block to idle. An illegal program parks the block with `fault` high until the next `start`.

The controller has seven states:
- IDLE waits for `start`.
- FETCH_OP reads the opcode byte.
- FETCH_ARG reads the operand bytes.
- EXEC carries out the instruction.
- ISSUE presents the descriptor.
- WAIT_ACK waits for completion.
- FAULT holds the error.

Its transitions are:
- IDLE→FETCH_OP on start.
- FETCH_OP→FETCH_ARG for opcodes with operands.
- FETCH_OP→EXEC for opcodes without operands.
- FETCH_OP→FAULT on an unknown opcode.
- FETCH_ARG→EXEC after the last operand byte.
- EXEC→IDLE on end.
- EXEC→ISSUE on a burst instruction.
- EXEC→FAULT on a loop misuse.
- EXEC→FETCH_OP otherwise.
- ISSUE→WAIT_ACK on `req_ready`.
- WAIT_ACK→FETCH_OP on `cmp_ack`.
- FAULT→FETCH_OP on start.

Top module: `dma_seq_channel`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `req_valid` are all 0. A `start` pulse while idle or faulted begins execution at program byte 0.
- R2: The opcode bytes are 0x00 end, 0x04 load, 0x08 store, 0x20 loop start, 0x38 loop end, 0xB0 set control word, 0xB1 set source address and 0xB2 set destination address. Each of the three set instructions is followed by a 4-byte immediate, least significant byte first. Loop start is followed by one count byte.
- R3: In the control word, bits [3:0] hold the source beats minus one, bit 4 selects 64-bit source beats (0 selects 32-bit), and bit 5 fixes the source address. Bits [11:8], 12 and 13 carry the same three fields for the destination.
- R4: A load presents a descriptor with `req_write`=0, the source address, `req_beats` = source field + 1, and the source width and fixed flag.
- R5: A store presents a descriptor with `req_write`=1, the destination address, and the destination beat count, width and fixed flag.
- R6: After a burst completes, its address register advances by beats × 4 bytes (32-bit beats) or beats × 8 bytes (64-bit beats). It does not move when its fixed flag is set. The next burst on that side starts from the resulting address.
- R7: A loop with count N runs its body N times, and a count of 0 runs it once. Loop end jumps back to the byte after the count byte.
- R8: Only one burst is outstanding at a time. The descriptor holds stable while `req_ready` is low, and no new descriptor appears until `cmp_ack` has been seen.
- R9: The end instruction raises `done` for exactly one cycle, after which `busy` is 0.
- R10: Each of these stops execution and holds `fault` high with no further descriptors until the next `start`:
  - an undefined opcode,
  - a loop start inside an active loop,
  - a loop end with no active loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin running the program from byte 0 |
| prog_we | input | 1 | Program memory write enable |
| prog_waddr | input | PC_W | Program memory byte address |
| prog_wdata | input | 8 | Program memory write byte |
| req_valid | output | 1 | Burst descriptor valid |
| req_ready | input | 1 | Descriptor accepted |
| req_write | output | 1 | 1 for a write burst, 0 for a read burst |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | 5 | Beats in the burst (1 to 16) |
| req_size64 | output | 1 | 1 for 64-bit beats, 0 for 32-bit beats |
| req_fixed | output | 1 | Address held constant across beats |
| cmp_ack | input | 1 | Completion pulse for the accepted burst |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse at program end |
| fault | output | 1 | Program stopped on an illegal instruction |

## Verification
Some rules can be judged every cycle from the ports alone, and the assertions cover those:
- the descriptor stays stable under backpressure;
- no descriptor appears while a burst awaits completion;
- `done` is a single-cycle pulse followed by idle;
- `fault` stays set and silent until restart.

Other behaviour only shows in the sequence of descriptors a whole program produces, so only the bench scenarios can demonstrate it:
- the byte order of the immediates;
- the field positions in the control word;
- address advance versus fixed mode;
- loop iteration counts, including a count of zero;
- where each unaligned burst starts.

The bench compares every descriptor against an interpreter of the program.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int IMM_W   = 32;
    localparam int LEN_W   = 4;
    localparam int CNT_W   = 8;
    localparam int BEATS_W = LEN_W + 1;

    typedef enum logic [7:0] {
        OP_END     = 8'h00,
        OP_LOAD    = 8'h04,
        OP_STORE   = 8'h08,
        OP_LOOP    = 8'h20,
        OP_LOOPEND = 8'h38,
        OP_MOV_CCR = 8'hB0,
        OP_MOV_SRC = 8'hB1,
        OP_MOV_DST = 8'hB2
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_OP,
        ST_FETCH_ARG,
        ST_EXEC,
        ST_ISSUE,
        ST_WAIT_ACK,
        ST_FAULT
    } state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             size64;
        logic             fixed;
    } side_cfg_t;

    function automatic side_cfg_t src_cfg(logic [IMM_W-1:0] c);
        side_cfg_t s;
        s.len_m1 = c[3:0];
        s.size64 = c[4];
        s.fixed  = c[5];
        return s;
    endfunction

    function automatic side_cfg_t dst_cfg(logic [IMM_W-1:0] c);
        side_cfg_t s;
        s.len_m1 = c[11:8];
        s.size64 = c[12];
        s.fixed  = c[13];
        return s;
    endfunction

    function automatic logic op_known(logic [7:0] op);
        case (op)
            OP_END, OP_LOAD, OP_STORE, OP_LOOP, OP_LOOPEND,
            OP_MOV_CCR, OP_MOV_SRC, OP_MOV_DST: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] arg_bytes(logic [7:0] op);
        case (op)
            OP_MOV_CCR, OP_MOV_SRC, OP_MOV_DST: return 3'd4;
            OP_LOOP:                            return 3'd1;
            default:                            return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_prog_mem.sv
module dma_seq_prog_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dma_seq_addr_unit.sv
module dma_seq_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IMM_W-1:0]  load_val,
    input  logic              advance,
    input  side_cfg_t         cfg,
    output logic [ADDR_W-1:0] addr
);

    localparam int STEP_W = LEN_W + 4;

    logic [STEP_W-1:0] beats;
    logic [STEP_W-1:0] step;

    always_comb begin
        beats = STEP_W'(cfg.len_m1) + STEP_W'(1);
        if (cfg.fixed) begin
            step = '0;
        end else if (cfg.size64) begin
            step = beats << 3;
        end else begin
            step = beats << 2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= ADDR_W'(load_val);
        end else if (advance) begin
            addr <= addr + ADDR_W'(step);
        end
    end

endmodule

// File: rtl/dma_seq_loop_ctr.sv
module dma_seq_loop_ctr
    import dma_seq_pkg::*;
#(
    parameter int PC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_count,
    input  logic [PC_W-1:0]  arm_pc,
    input  logic             close,
    output logic             active,
    output logic             back,
    output logic [PC_W-1:0]  ret_pc
);

    logic [CNT_W-1:0] cnt_q;

    assign back = active && (cnt_q > CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
            ret_pc <= '0;
        end else if (clear) begin
            active <= 1'b0;
        end else if (arm) begin
            active <= 1'b1;
            cnt_q  <= arm_count;
            ret_pc <= arm_pc;
        end else if (close) begin
            if (back) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_seq_channel.sv
module dma_seq_channel
    import dma_seq_pkg::*;
#(
    parameter int PROG_DEPTH = 64,
    parameter int ADDR_W     = 32,
    localparam int PC_W      = $clog2(PROG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prog_we,
    input  logic [PC_W-1:0]   prog_waddr,
    input  logic [7:0]        prog_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BEATS_W-1:0] req_beats,
    output logic              req_size64,
    output logic              req_fixed,
    input  logic              cmp_ack,
    output logic              busy,
    output logic              done,
    output logic              fault
);

    state_e            state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic [7:0]        opcode_q;
    logic [IMM_W-1:0]  imm_q;
    logic [2:0]        argcnt_q;
    logic [IMM_W-1:0]  ccr_q;
    logic [7:0]        rdata;

    side_cfg_t         scfg, dcfg, cur_cfg;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic              in_exec, is_store, restart;
    logic              loop_active, loop_back;
    logic [PC_W-1:0]   loop_pc;

    assign scfg     = src_cfg(ccr_q);
    assign dcfg     = dst_cfg(ccr_q);
    assign in_exec  = (state_q == ST_EXEC);
    assign is_store = (opcode_q == OP_STORE);
    assign cur_cfg  = is_store ? dcfg : scfg;
    assign restart  = start && (state_q == ST_IDLE || state_q == ST_FAULT);

    dma_seq_prog_mem #(.DEPTH(PROG_DEPTH)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_waddr),
        .wdata (prog_wdata),
        .raddr (pc_q),
        .rdata (rdata)
    );

    dma_seq_addr_unit #(.ADDR_W(ADDR_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_exec && opcode_q == OP_MOV_SRC),
        .load_val (imm_q),
        .advance  (state_q == ST_WAIT_ACK && cmp_ack && !is_store),
        .cfg      (scfg),
        .addr     (src_addr)
    );

    dma_seq_addr_unit #(.ADDR_W(ADDR_W)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_exec && opcode_q == OP_MOV_DST),
        .load_val (imm_q),
        .advance  (state_q == ST_WAIT_ACK && cmp_ack && is_store),
        .cfg      (dcfg),
        .addr     (dst_addr)
    );

    dma_seq_loop_ctr #(.PC_W(PC_W)) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .arm       (in_exec && opcode_q == OP_LOOP && !loop_active),
        .arm_count (imm_q[IMM_W-1 -: CNT_W]),
        .arm_pc    (pc_q),
        .close     (in_exec && opcode_q == OP_LOOPEND && loop_active),
        .active    (loop_active),
        .back      (loop_back),
        .ret_pc    (loop_pc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (start) state_d = ST_FETCH_OP;
            end
            ST_FETCH_OP: begin
                if (!op_known(rdata))             state_d = ST_FAULT;
                else if (arg_bytes(rdata) != 3'd0) state_d = ST_FETCH_ARG;
                else                               state_d = ST_EXEC;
            end
            ST_FETCH_ARG: begin
                if (argcnt_q == 3'd1) state_d = ST_EXEC;
            end
            ST_EXEC: begin
                case (opcode_q)
                    OP_END:             state_d = ST_IDLE;
                    OP_LOAD, OP_STORE:  state_d = ST_ISSUE;
                    OP_LOOP:            state_d = loop_active ? ST_FAULT : ST_FETCH_OP;
                    OP_LOOPEND:         state_d = loop_active ? ST_FETCH_OP : ST_FAULT;
                    default:            state_d = ST_FETCH_OP;
                endcase
            end
            ST_ISSUE: begin
                if (req_ready) state_d = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (cmp_ack) state_d = ST_FETCH_OP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Instruction datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            opcode_q <= 8'h00;
            imm_q    <= '0;
            argcnt_q <= '0;
            ccr_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FAULT: begin
                    if (start) pc_q <= '0;
                end
                ST_FETCH_OP: begin
                    opcode_q <= rdata;
                    pc_q     <= pc_q + PC_W'(1);
                    argcnt_q <= arg_bytes(rdata);
                end
                ST_FETCH_ARG: begin
                    imm_q    <= {rdata, imm_q[IMM_W-1:8]};
                    pc_q     <= pc_q + PC_W'(1);
                    argcnt_q <= argcnt_q - 3'd1;
                end
                ST_EXEC: begin
                    if (opcode_q == OP_MOV_CCR) begin
                        ccr_q <= imm_q;
                    end else if (opcode_q == OP_LOOPEND && loop_back) begin
                        pc_q <= loop_pc;
                    end
                end
                ST_ISSUE, ST_WAIT_ACK: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_valid  = (state_q == ST_ISSUE);
        req_write  = is_store;
        req_addr   = is_store ? dst_addr : src_addr;
        req_beats  = BEATS_W'(cur_cfg.len_m1) + BEATS_W'(1);
        req_size64 = cur_cfg.size64;
        req_fixed  = cur_cfg.fixed;
        busy       = (state_q != ST_IDLE) && (state_q != ST_FAULT);
        done       = in_exec && (opcode_q == OP_END);
        fault      = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/dma_seq_channel_chk.sv
module dma_seq_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [4:0]        req_beats,
    input logic              cmp_ack,
    input logic              busy,
    input logic              done,
    input logic              fault
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            pend_q <= 1'b1;
        end else if (cmp_ack) begin
            pend_q <= 1'b0;
        end
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R1

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_write) && $stable(req_beats)); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !req_valid); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R9

    AST_DONE_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R9

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !start |=> fault); // R10

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req_valid && !busy); // R10

endmodule

bind dma_seq_channel dma_seq_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_beats (req_beats),
    .cmp_ack   (cmp_ack),
    .busy      (busy),
    .done      (done),
    .fault     (fault)
);

// File: tb/dma_seq_channel_tb_top.sv
module dma_seq_channel_tb_top;

    localparam int DEPTH = 64;
    localparam int MAXB  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_waddr = '0;
    logic [7:0]  prog_wdata = '0;
    logic        req_valid, req_write, req_size64, req_fixed;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [4:0]  req_beats;
    logic        cmp_ack = 1'b0;
    logic        busy, done, fault;

    always #4 clk = ~clk;

    dma_seq_channel dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_we(prog_we), .prog_waddr(prog_waddr), .prog_wdata(prog_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_beats(req_beats), .req_size64(req_size64),
        .req_fixed(req_fixed), .cmp_ack(cmp_ack),
        .busy(busy), .done(done), .fault(fault)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  prog [DEPTH];
    int          plen;
    logic        exp_w [MAXB];
    logic [31:0] exp_a [MAXB];
    int          exp_b [MAXB];
    logic        exp_s [MAXB];
    logic        exp_f [MAXB];
    int          exp_n;
    bit          exp_fault;
    logic [31:0] m_ccr = '0, m_sar = '0, m_dar = '0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) prog[i] = 8'h00;
        plen = 0;
    endtask

    task automatic emit(logic [7:0] b);
        prog[plen % DEPTH] = b;
        plen++;
    endtask

    task automatic emit_mov(logic [7:0] op, logic [31:0] v);
        emit(op); emit(v[7:0]); emit(v[15:8]); emit(v[23:16]); emit(v[31:24]);
    endtask

    function automatic logic [31:0] mk_ccr(int sl, bit ss, bit sf, int dl, bit ds, bit df);
        return 32'(sl) | (32'(ss) << 4) | (32'(sf) << 5)
             | (32'(dl) << 8) | (32'(ds) << 12) | (32'(df) << 13);
    endfunction

    task automatic add_burst(bit w);
        int          beats;
        bit          sz, fx;
        logic [31:0] a;
        beats = int'(w ? m_ccr[11:8] : m_ccr[3:0]) + 1;
        sz    = w ? m_ccr[12] : m_ccr[4];
        fx    = w ? m_ccr[13] : m_ccr[5];
        a     = w ? m_dar : m_sar;
        if (exp_n < MAXB) begin
            exp_w[exp_n] = w; exp_a[exp_n] = a; exp_b[exp_n] = beats;
            exp_s[exp_n] = sz; exp_f[exp_n] = fx;
        end
        exp_n++;
        if (!fx) a = a + 32'(beats * (sz ? 8 : 4));
        if (w) m_dar = a; else m_sar = a;
    endtask

    // Reference interpreter written from R2, R3, R6, R7 and R10
    task automatic model();
        int pc = 0; int cnt = 0; int lpc = 0; bit act = 0; bit fin = 0;
        logic [7:0]  op;
        logic [31:0] v;
        exp_n = 0; exp_fault = 0;
        for (int steps = 0; steps < 5000 && !fin; steps++) begin
            op = prog[pc % DEPTH]; pc++;
            case (op)
                8'h00: fin = 1;
                8'h04: add_burst(1'b0);
                8'h08: add_burst(1'b1);
                8'hB0, 8'hB1, 8'hB2: begin
                    v = {prog[(pc+3) % DEPTH], prog[(pc+2) % DEPTH],
                         prog[(pc+1) % DEPTH], prog[pc % DEPTH]};
                    pc += 4;
                    if (op == 8'hB0) m_ccr = v;
                    else if (op == 8'hB1) m_sar = v;
                    else m_dar = v;
                end
                8'h20: begin
                    cnt = int'(prog[pc % DEPTH]); pc++;
                    if (act) begin exp_fault = 1; fin = 1; end
                    else begin act = 1; lpc = pc; end
                end
                8'h38: begin
                    if (!act) begin exp_fault = 1; fin = 1; end
                    else if (cnt > 1) begin cnt--; pc = lpc; end
                    else act = 0;
                end
                default: begin exp_fault = 1; fin = 1; end
            endcase
            pc = pc % DEPTH;
        end
    endtask

    task automatic run_prog(string name);
        int got = 0; bit fin = 0; bit saw_done = 0;
        model();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_waddr = 6'(i); prog_wdata = prog[i];
        end
        @(negedge clk); prog_we = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(fault == 1'b0, "R1 fault cleared by start", 32'(fault), 0);
        for (int cyc = 0; cyc < 40000 && !fin; cyc++) begin
            if (done) begin
                saw_done = 1; fin = 1;
            end else if (fault) begin
                fin = 1;
            end else if (req_valid) begin
                chk(got < exp_n, "R8 unexpected burst", 32'(got), 32'(exp_n));
                if (got < exp_n && got < MAXB) begin
                    chk(req_write == exp_w[got], exp_w[got] ? "R5 direction" : "R4 direction",
                        32'(req_write), 32'(exp_w[got]));
                    chk(req_addr == exp_a[got], "R6 burst address", req_addr, exp_a[got]);
                    chk(int'(req_beats) == exp_b[got] && req_size64 == exp_s[got]
                        && req_fixed == exp_f[got], "R3 beats/size/fixed",
                        {req_fixed, req_size64, 3'b0, req_beats},
                        {exp_f[got], exp_s[got], 3'b0, 5'(exp_b[got])});
                end
                repeat ($urandom_range(0, 2)) @(negedge clk);
                req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
                repeat ($urandom_range(0, 3)) begin
                    @(negedge clk);
                    chk(!req_valid, "R8 descriptor before completion", 32'(req_valid), 0);
                end
                cmp_ack = 1'b1; @(negedge clk); cmp_ack = 1'b0;
                got++;
            end else begin
                @(negedge clk);
            end
        end
        if (!exp_fault) begin
            @(negedge clk);
            chk(!done && !busy, "R9 done pulse then idle", {busy, done}, 0);
        end else begin
            repeat (3) @(negedge clk);
            chk(fault && !busy && !req_valid, "R10 fault held quiet",
                {fault, busy, req_valid}, 32'b100);
        end
        chk(got == exp_n, {"R7 burst count ", name}, 32'(got), 32'(exp_n));
        chk(saw_done == !exp_fault, {"R9 end seen ", name}, 32'(saw_done), 32'(!exp_fault));
        chk(fault == exp_fault, {"R10 fault state ", name}, 32'(fault), 32'(exp_fault));
    endtask

    task automatic rand_op();
        int r = $urandom_range(0, 4);
        if (r < 2) emit(8'h04);
        else if (r < 4) emit(8'h08);
        else emit_mov(8'hB0, mk_ccr($urandom_range(0, 4), 1'($urandom), 1'($urandom),
                                    $urandom_range(0, 4), 1'($urandom), 1'($urandom)));
    endtask

    task automatic gen_random();
        clear_prog();
        emit_mov(8'hB0, mk_ccr($urandom_range(0, 4), 1'($urandom), 1'($urandom),
                               $urandom_range(0, 4), 1'($urandom), 1'($urandom)));
        emit_mov(8'hB1, {$urandom_range(0, 65535), 2'b00} + 32'h1000_0000);
        emit_mov(8'hB2, {$urandom_range(0, 65535), 2'b00} + 32'h2000_0000);
        repeat ($urandom_range(1, 3)) rand_op();
        emit(8'h20); emit(8'($urandom_range(0, 6)));
        repeat ($urandom_range(1, 3)) rand_op();
        emit(8'h38);
        rand_op();
        emit(8'h00);
    endtask

    int wd_cycles = 0;
    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", wd_cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !req_valid, "R1 reset state",
            {busy, done, fault, req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !req_valid, "R1 idle without start", {busy, req_valid}, 0);

        // Unaligned continuation: 5-beat 64-bit load, then shorter tails (R2 R6 R7)
        clear_prog();
        emit_mov(8'hB0, mk_ccr(4, 1, 0, 3, 1, 0));
        emit_mov(8'hB1, 32'h0000_1004);
        emit_mov(8'hB2, 32'h0000_4000);
        emit(8'h04); emit(8'h08);
        emit_mov(8'hB0, mk_ccr(3, 1, 0, 3, 1, 0));
        emit(8'h20); emit(8'd14); emit(8'h04); emit(8'h08); emit(8'h38);
        emit_mov(8'hB0, mk_ccr(2, 1, 0, 3, 1, 0));
        emit(8'h04);
        emit_mov(8'hB0, mk_ccr(0, 0, 0, 3, 1, 0));
        emit(8'h04); emit(8'h08); emit(8'h00);
        run_prog("unaligned");
        chk(exp_a[2] == 32'h0000_102C, "R6 second load after 40 bytes", exp_a[2], 32'h102C);

        // Fixed destination with 32-bit beats, loop of 16 (R5 R6)
        clear_prog();
        emit_mov(8'hB0, mk_ccr(1, 1, 0, 3, 0, 1));
        emit_mov(8'hB1, 32'h0000_1000);
        emit_mov(8'hB2, 32'h0000_4000);
        emit(8'h20); emit(8'd16); emit(8'h04); emit(8'h08); emit(8'h38);
        emit(8'h00);
        run_prog("fixed_dst");

        // Loop count zero runs body once (R7)
        clear_prog();
        emit(8'h20); emit(8'd0); emit(8'h04); emit(8'h38); emit(8'h00);
        run_prog("loop_zero");

        // Undefined opcode (R10)
        clear_prog();
        emit(8'h04); emit(8'h5A); emit(8'h08); emit(8'h00);
        run_prog("bad_opcode");

        // Nested loop start (R10), then restart from fault
        clear_prog();
        emit(8'h20); emit(8'd3); emit(8'h20); emit(8'd2); emit(8'h38); emit(8'h00);
        run_prog("nested_loop");

        // Loop end without loop (R10)
        clear_prog();
        emit(8'h08); emit(8'h38); emit(8'h00);
        run_prog("stray_loopend");

        // Immediate byte order (R2)
        clear_prog();
        emit_mov(8'hB1, 32'h1122_3344);
        emit(8'h04); emit(8'h00);
        run_prog("byte_order");

        for (int t = 0; t < 14; t++) begin
            gen_random();
            run_prog("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule